// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

This block turns a demodulated infrared remote-control line into a table of duration counts, so that software can decode any remote protocol. The line is idle-high and active-low. After it is resynchronised, the block waits for the first falling edge and then measures each low stretch (pulse) and high stretch (space) as an 8-bit count of sample ticks. The counts are packed four to a 32-bit word in a bank of read-only capture words.

A sample tick comes from the system clock divided by four, then divided again by a programmable period. A message ends when a space count saturates at 255. Capture also ends when every table entry is full. Either ending sets an interrupt pending flag, which can be masked. After reading the table, software clears the flag and writes a restart command. The restart wipes the table and re-arms the block for the next message.

The register port is a simple single-cycle bus. Writes are strobed and reads are combinational.

Top module: `ir_capture_ctrl`

## Requirements
- R1: After reset, irq is low. Every capture word reads zero. Offset 0x0C reads 0, and offset 0x10 reads 0x000C0000, which is a period of 0xC00.
- R2: Register map. Offset 0x0C holds a receiver-on bit at bit 0 and a measure-on bit at bit 13. Offset 0x10 holds the 13-bit sample period N at bits 20:8. Offset 0xCC holds the interrupt enable at bit 0. These three read back what was written. Capture words cannot be written. Unmapped offsets read zero and ignore writes.
- R3: Capture runs only while both enable bits are set. With either bit clear, falling edges on ir_in start nothing and the table stays zero.
- R4: Every entry restarts the sample timebase. An entry whose level lasts D clock cycles stores floor((D-1)/(4N)), saturated at 255.
- R5: Entry k sits in capture word k/4 at offset 0x88 + 4*(k/4), in bits 8*(k%4)+7 : 8*(k%4). Entry 0 is always the first pulse, and entries then alternate pulse, space, pulse and so on.
- R6: A space whose count reaches 255 is stored as 255 and ends the message. A pulse count stops at 255 and is stored when the line rises.
- R7: Capture stops once all 68 entries have been written. Later edges on ir_in change nothing.
- R8: The end of a message or a full table sets the pending flag. irq equals the pending flag AND the enable at 0xCC.
- R9: Writing 1 to bit 0 of 0xD0 clears the pending flag. This clear wins over a set in the same cycle.
- R10: Writing 1 to bit 0 of 0x20 clears every capture word and returns the block to waiting for a first falling edge. The pending flag is left unchanged.
- R11: While waiting, a high line or a rising edge stores nothing. Only a falling edge starts entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ir_in | input | 1 | Demodulated IR line, idle-high, asynchronous |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume the following about the inputs:
- bus_we is a single-cycle strobe with a stable address.
- ir_in may change at any time, because it is resynchronised before use.
- The period register is never zero while a timing-sensitive check is running.

The stimulus follows these rules:
- Bus writes are driven on falling clock edges.
- IR edges are spaced a whole number of cycles apart.
- Every duration is chosen half a sample away from a tick boundary, so each expected count is exact.
- The sample period is set to 1 before any timed message.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  // register offsets (byte addresses)
  localparam logic [ADDR_W-1:0] OFF_ENABLE  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_PERIOD  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RESTART = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CAP0    = 8'h88;
  localparam logic [ADDR_W-1:0] OFF_IRQ_EN  = 8'hCC;
  localparam logic [ADDR_W-1:0] OFF_IRQ_CLR = 8'hD0;

  localparam int BIT_RX_ON   = 0;
  localparam int BIT_MEAS_ON = 13;
  localparam int PERIOD_LSB  = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_DONE = 2'd2
  } cap_state_e;
endpackage

// File: rtl/ir_cap_sync.sv
module ir_cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic lvl_prev
);
  logic [STAGES:0] chain_q;

  generate
    for (genvar s = 0; s <= STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign lvl      = chain_q[STAGES-1];
  assign lvl_prev = chain_q[STAGES];
endmodule

// File: rtl/ir_cap_timebase.sv
module ir_cap_timebase #(
  parameter int PRE_DIV = 4,
  parameter int PER_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             resync,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  localparam int DIV_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRE_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             div_wrap, per_wrap;

  always_comb begin
    div_wrap = (div_q == DIV_LAST);
    per_wrap = ({1'b0, per_q} + (PER_W+1)'(1)) >= {1'b0, period};
    tick     = run && !resync && div_wrap && per_wrap;
    div_d    = div_q;
    per_d    = per_q;
    if (resync) begin
      div_d = '0;
      per_d = '0;
    end else if (run) begin
      div_d = div_wrap ? '0 : div_q + DIV_W'(1);
      if (div_wrap) per_d = per_wrap ? '0 : per_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      per_q <= '0;
    end else begin
      div_q <= div_d;
      per_q <= per_d;
    end
  end

  // R4: the prescaler keeps consecutive ticks apart
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/ir_cap_engine.sv
module ir_cap_engine
  import ir_cap_pkg::*;
#(
  parameter int ENTRIES = 68,
  parameter int ENTRY_W = 8,
  parameter int IDX_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic               tick,
  input  logic               ir_lvl,
  input  logic               ir_prev,
  output logic               tb_resync,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [ENTRY_W-1:0] wr_val,
  output logic               finish
);
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(ENTRIES - 1);
  localparam logic [ENTRY_W-1:0] CNT_MAX  = '1;

  cap_state_e         st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [ENTRY_W-1:0] cnt_q, cnt_d;
  logic               fall, change, in_space;

  always_comb begin
    fall      = ir_prev && !ir_lvl;
    change    = ir_prev ^ ir_lvl;
    in_space  = idx_q[0];
    st_d      = st_q;
    idx_d     = idx_q;
    cnt_d     = cnt_q;
    wr_en     = 1'b0;
    wr_val    = cnt_q;
    tb_resync = 1'b0;
    finish    = 1'b0;
    if (restart) begin
      st_d  = ST_IDLE;
      idx_d = '0;
      cnt_d = '0;
    end else if (run) begin
      case (st_q)
        ST_IDLE: begin
          if (fall) begin
            st_d      = ST_CAPT;
            idx_d     = '0;
            cnt_d     = '0;
            tb_resync = 1'b1;
          end
        end
        ST_CAPT: begin
          if (change) begin
            wr_en     = 1'b1;
            tb_resync = 1'b1;
            cnt_d     = '0;
            if (idx_q == LAST_IDX) begin
              st_d   = ST_DONE;
              finish = 1'b1;
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end else if (tick && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + ENTRY_W'(1);
            if (in_space && cnt_q == CNT_MAX - ENTRY_W'(1)) begin
              wr_en  = 1'b1;
              wr_val = CNT_MAX;
              st_d   = ST_DONE;
              finish = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_idx = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  // R7: no store beyond the table, none once capture has stopped
  a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx <= LAST_IDX));
  a_r7_frozen_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && !restart) |=> (st_q == ST_DONE && !wr_en));
  // R5: every message begins at entry 0
  a_r5_first_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAPT && $past(st_q) == ST_IDLE) |-> (idx_q == '0));
  // R11: waiting stores nothing
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !wr_en);
endmodule

// File: rtl/ir_cap_regs.sv
module ir_cap_regs
  import ir_cap_pkg::*;
#(
  parameter int             NUM_WORDS = 17,
  parameter int             ENTRY_W   = 8,
  parameter int             PER_W     = 13,
  parameter logic [PER_W-1:0] PER_RST = 13'hC00,
  parameter int             IDX_W     = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_we,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_val,
  input  logic               finish,
  output logic               run,
  output logic               restart,
  output logic [PER_W-1:0]   period,
  output logic               irq
);
  localparam int PER_WORD = DATA_W / ENTRY_W;
  localparam int ENTRIES  = NUM_WORDS * PER_WORD;

  logic               rx_on_q, meas_on_q, ie_q, pend_q, pend_d;
  logic [PER_W-1:0]   per_q;
  logic               wr_enable, wr_period, wr_ie, clr_pend;
  logic [ENTRY_W-1:0] ent_q [ENTRIES];
  logic [DATA_W-1:0]  cap_word [NUM_WORDS];
  logic [ADDR_W-1:0]  cap_off;

  always_comb begin
    wr_enable = bus_we && bus_addr == OFF_ENABLE;
    wr_period = bus_we && bus_addr == OFF_PERIOD;
    wr_ie     = bus_we && bus_addr == OFF_IRQ_EN;
    clr_pend  = bus_we && bus_addr == OFF_IRQ_CLR && bus_wdata[0];
    restart   = bus_we && bus_addr == OFF_RESTART && bus_wdata[0];
    pend_d    = pend_q;
    if (finish)   pend_d = 1'b1;
    if (clr_pend) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on_q   <= 1'b0;
      meas_on_q <= 1'b0;
      per_q     <= PER_RST;
      ie_q      <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (wr_enable) begin
        rx_on_q   <= bus_wdata[BIT_RX_ON];
        meas_on_q <= bus_wdata[BIT_MEAS_ON];
      end
      if (wr_period) per_q <= bus_wdata[PERIOD_LSB +: PER_W];
      if (wr_ie)     ie_q  <= bus_wdata[0];
      pend_q <= pend_d;
    end
  end

  generate
    for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ent_q[k] <= '0;
        else if (restart)                        ent_q[k] <= '0;
        else if (wr_en && wr_idx == IDX_W'(k))   ent_q[k] <= wr_val;
      end
    end
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      for (genvar b = 0; b < PER_WORD; b++) begin : g_byte
        assign cap_word[w][b*ENTRY_W +: ENTRY_W] = ent_q[w*PER_WORD + b];
      end
    end
  endgenerate

  always_comb begin
    cap_off   = bus_addr - OFF_CAP0;
    bus_rdata = '0;
    case (bus_addr)
      OFF_ENABLE: begin
        bus_rdata[BIT_RX_ON]   = rx_on_q;
        bus_rdata[BIT_MEAS_ON] = meas_on_q;
      end
      OFF_PERIOD: bus_rdata[PERIOD_LSB +: PER_W] = per_q;
      OFF_IRQ_EN: bus_rdata[0] = ie_q;
      default: begin
        if (bus_addr >= OFF_CAP0 && cap_off[1:0] == 2'b00) begin
          for (int w = 0; w < NUM_WORDS; w++) begin
            if (int'(cap_off[ADDR_W-1:2]) == w) bus_rdata = cap_word[w];
          end
        end
      end
    endcase
  end

  assign run    = rx_on_q && meas_on_q;
  assign period = per_q;
  assign irq    = pend_q && ie_q;

  // R9: a clear write always leaves the flag low
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |=> !pend_q);
  // R8: the flag only rises after the engine reports an end
  a_r8_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(finish));
  // R10: restart empties the first capture word
  a_r10_restart_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cap_word[0] == '0));
endmodule

// File: rtl/ir_capture_ctrl.sv
module ir_capture_ctrl
  import ir_cap_pkg::*;
#(
  parameter int             NUM_WORDS = 17,
  parameter int             ENTRY_W   = 8,
  parameter int             PER_W     = 13,
  parameter logic [PER_W-1:0] PER_RST = 13'hC00,
  parameter int             PRE_DIV   = 4,
  parameter int             SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              ir_in,
  output logic              irq
);
  localparam int ENTRIES = NUM_WORDS * (DATA_W / ENTRY_W);
  localparam int IDX_W   = $clog2(ENTRIES);

  logic               ir_lvl, ir_prev, run, restart, tick, resync;
  logic               tb_resync, wr_en, finish;
  logic [IDX_W-1:0]   wr_idx;
  logic [ENTRY_W-1:0] wr_val;
  logic [PER_W-1:0]   period;

  assign resync = tb_resync || restart;

  ir_cap_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ir_in), .lvl(ir_lvl), .lvl_prev(ir_prev));

  ir_cap_timebase #(.PRE_DIV(PRE_DIV), .PER_W(PER_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .resync(resync),
    .period(period), .tick(tick));

  ir_cap_engine #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .tick(tick),
    .ir_lvl(ir_lvl), .ir_prev(ir_prev), .tb_resync(tb_resync),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .finish(finish));

  ir_cap_regs #(.NUM_WORDS(NUM_WORDS), .ENTRY_W(ENTRY_W), .PER_W(PER_W),
                .PER_RST(PER_RST), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_val(wr_val), .finish(finish), .run(run), .restart(restart),
    .period(period), .irq(irq));
endmodule

// File: tb/ir_capture_ctrl_test.sv
module ir_capture_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        ir_in = 1'b1;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ir_capture_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .ir_in(ir_in), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // hold the line at lvl for a duration worth w samples with N = 1
  task automatic level_for(input logic lvl, input int w);
    @(negedge clk);
    ir_in = lvl;
    repeat (4*w + 1) @(negedge clk);
  endtask

  function automatic logic [7:0] pattern_width(input int k);
    return 8'((k % 7) + 1);
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 32'h0);
    bus_read(8'h0C, v); check("R1 enable", v, 32'h0);
    bus_read(8'h10, v); check("R1 period", v, 32'h000C0000);
    bus_read(8'h88, v); check("R1 word0", v, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    bus_write(8'h10, 32'h00000100);
    bus_read(8'h10, v); check("R2 period", v, 32'h00000100);
    bus_write(8'hCC, 32'h1);
    bus_read(8'hCC, v); check("R2 irq enable", v, 32'h1);
    bus_write(8'h44, 32'hFFFFFFFF);
    bus_read(8'h44, v); check("R2 unmapped", v, 32'h0);
    bus_write(8'h88, 32'hFFFFFFFF);
    bus_read(8'h88, v); check("R2 capture read-only", v, 32'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    bus_write(8'h0C, 32'h1);
    level_for(1'b0, 3);
    level_for(1'b1, 5);
    idle(20);
    bus_read(8'h88, v); check("R3 no capture with one enable", v, 32'h0);
    check("R3 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_message;
    logic [31:0] v;
    bus_write(8'h0C, 32'h2001);
    bus_read(8'h0C, v); check("R2 enable readback", v, 32'h2001);
    idle(10);
    level_for(1'b0, 3);
    level_for(1'b1, 5);
    level_for(1'b0, 2);
    @(negedge clk); ir_in = 1'b1;
    idle(1100);
    bus_read(8'h88, v); check("R4 R5 R6 widths", v, 32'hFF020503);
    bus_read(8'h8C, v); check("R5 word1", v, 32'h0);
    check("R8 irq raised", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_clear;
    bus_write(8'hD0, 32'h1);
    idle(2);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_restart_saturate;
    logic [31:0] v;
    bus_write(8'h20, 32'h1);
    bus_read(8'h88, v); check("R10 wipe", v, 32'h0);
    idle(200);
    bus_read(8'h88, v); check("R11 high line stores nothing", v, 32'h0);
    @(negedge clk); ir_in = 1'b0;
    idle(1200);
    @(negedge clk); ir_in = 1'b1;
    idle(1100);
    bus_read(8'h88, v); check("R6 pulse and space saturate", v, 32'h0000FFFF);
    bus_write(8'hD0, 32'h1);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    logic [31:0] exp;
    bus_write(8'hCC, 32'h0);
    bus_write(8'h20, 32'h1);
    idle(5);
    for (int k = 0; k < 68; k++) begin
      level_for(k[0] ? 1'b1 : 1'b0, int'(pattern_width(k)));
    end
    @(negedge clk); ir_in = 1'b0;
    idle(10);
    level_for(1'b1, 2);
    level_for(1'b0, 2);
    @(negedge clk); ir_in = 1'b1;
    idle(1100);
    for (int w = 0; w < 17; w++) begin
      exp = {pattern_width(4*w+3), pattern_width(4*w+2),
             pattern_width(4*w+1), pattern_width(4*w)};
      bus_read(8'(8'h88 + 4*w), v);
      check("R7 full table", v, exp);
    end
    check("R8 masked irq", {31'b0, irq}, 32'h0);
    bus_write(8'hCC, 32'h1);
    idle(1);
    check("R8 unmasked irq", {31'b0, irq}, 32'h1);
    bus_write(8'h20, 32'h1);
    idle(1);
    check("R10 pending kept across restart", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_regs();
    t_disabled();
    t_message();
    t_clear();
    t_restart_saturate();
    t_overflow();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule